// File: doc/BRIEF.md
# Handset Power-Up Sequencing Controller

This block is the digital sequencer that turns a portable handset on and off. A power-up starts either from a keypad press that has stayed down long enough to be trusted or from an external supply becoming present. The controller enables regulator 1 first. After regulator 1 reports power-good it waits a fixed gap and then enables regulator 2. Once both regulators report power-good, a reset timer runs and the system reset is then released.

After reset is released, the host processor must raise a hold line within a fixed window. If the host does this, or if the external supply is present, the system stays on. If hold later drops while the external supply is absent, or if the window expires without hold, the controller shuts down in reverse order: reset falls, then regulator 2 turns off, then regulator 1. While the system is on, a fresh trusted keypad press pulls an active-low, open-drain-style interrupt toward the host.

All delays are parameters counted in clock cycles. All inputs are taken as synchronous to `clk`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: From the off state, a power-up starts only after `key_in` has been high for `DEB_CYC` consecutive clock edges. `reg1_en` rises `DEB_CYC+1` cycles after `key_in` is first driven high. A press of `DEB_CYC-1` cycles or fewer leaves every output unchanged.
- R2: From the off state, `ext_pwr_in` high sets `reg1_en` one cycle later. `reg2_en` is never high while `reg1_en` is low.
- R3: While `reg1_en` is on and regulator 2 is still off, `reg2_en` stays low until `pg1_in` is high. `reg2_en` then rises `EN2_DLY+1` cycles after `pg1_in` is first seen high.
- R4: With `reg2_en` on, `sys_rst_n` stays low until `pg1_in` and `pg2_in` are both high. It rises `RST_DLY+1` cycles after both are first seen high. `sys_rst_n` is high only while both enables are high.
- R5: If `hold_in` is not seen high within `HOLD_WIN` cycles of `sys_rst_n` rising, and `ext_pwr_in` is low, `sys_rst_n` falls `HOLD_WIN+FALL_DLY` cycles after it rose. If `hold_in` is raised inside the window, the system stays on past the window.
- R6: In the on state with `ext_pwr_in` low, `hold_in` going low drives `sys_rst_n` low `FALL_DLY+1` cycles later.
- R7: During shutdown, `reg2_en` falls `OFF2_DLY` cycles after `sys_rst_n` falls, and `reg1_en` falls `OFF1_DLY` cycles after `reg2_en` falls. The controller then returns to the off state.
- R8: In the on state, a keypad press held `DEB_CYC` edges drives `irq_n` low (0 = pulled low, 1 = released) `DEB_CYC+1` cycles after the press starts. `irq_n` is released two cycles after the key is released. Such a press does not change the enables or `sys_rst_n`.
- R9: While `ext_pwr_in` is high, neither window expiry nor a drop of `hold_in` starts a shutdown. Shutdown begins once both are low, with `sys_rst_n` falling `FALL_DLY+1` cycles after the last of them drops.
- R10: Synchronous `rst` high gives, one cycle later: both enables low, `sys_rst_n` low, `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_in | input | 1 | Raw keypad power key, 1 = pressed |
| ext_pwr_in | input | 1 | External supply present |
| hold_in | input | 1 | Host keep-alive handshake |
| pg1_in | input | 1 | Regulator 1 power-good flag |
| pg2_in | input | 1 | Regulator 2 power-good flag |
| reg1_en | output | 1 | Regulator 1 enable |
| reg2_en | output | 1 | Regulator 2 enable |
| sys_rst_n | output | 1 | System reset, active low |
| irq_n | output | 1 | Interrupt, 0 = pull low, 1 = released |

## Verification
The hardest situation to reach from the ports is a window expiry while the external supply is present. The controller has to go through a full trusted power-up and sit in the hold window without the handshake, then enter the on state anyway. The stimulus starts the system from `ext_pwr_in` with both power-good flags already high. It lets the window run out, then toggles `hold_in` to show the drop is ignored, and only then releases the supply to watch the reverse shutdown. The keypad interrupt is reached the same way: it needs a second debounced press while the system is already on.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        SQ_OFF,
        SQ_UP1,
        SQ_GAP2,
        SQ_UP2,
        SQ_RSTDLY,
        SQ_WIN,
        SQ_ON,
        SQ_DROP,
        SQ_DN2,
        SQ_DN1
    } seq_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_key_filter.sv
module pwr_key_filter #(
    parameter int unsigned DEB_CYC = 32000
) (
    input  logic clk,
    input  logic rst,
    input  logic key_in,
    output logic key_held
);
    localparam int unsigned FW = $clog2(DEB_CYC + 1);
    localparam logic [FW-1:0] FULL = FW'(DEB_CYC);

    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!key_in)
            cnt_d = '0;
        else if (cnt_q == FULL)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign key_held = (cnt_q == FULL);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int unsigned EN2_DLY  = 500,
    parameter int unsigned RST_DLY  = 20000,
    parameter int unsigned HOLD_WIN = 500000,
    parameter int unsigned FALL_DLY = 100,
    parameter int unsigned OFF2_DLY = 1000,
    parameter int unsigned OFF1_DLY = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic key_held,
    input  logic ext_pwr_in,
    input  logic hold_in,
    input  logic pg1_in,
    input  logic pg2_in,
    output logic reg1_en,
    output logic reg2_en,
    output logic sys_rst_n,
    output logic irq_n
);
    localparam int unsigned MAXD = max2(max2(max2(EN2_DLY, RST_DLY), max2(HOLD_WIN, FALL_DLY)),
                                        max2(OFF2_DLY, OFF1_DLY));
    localparam int unsigned CW = $clog2(MAXD + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          key_prev;
        logic          irq;
    } regs_t;

    regs_t d, q;
    logic [CW-1:0] lim;
    logic done, key_rise;

    always_comb begin
        case (q.st)
            SQ_GAP2:   lim = CW'(EN2_DLY);
            SQ_RSTDLY: lim = CW'(RST_DLY);
            SQ_WIN:    lim = CW'(HOLD_WIN);
            SQ_DROP:   lim = CW'(FALL_DLY);
            SQ_DN2:    lim = CW'(OFF2_DLY);
            SQ_DN1:    lim = CW'(OFF1_DLY);
            default:   lim = CW'(1);
        endcase
        done     = (q.cnt == lim - 1'b1);
        key_rise = key_held && !q.key_prev;

        d          = q;
        d.key_prev = key_held;
        d.irq      = 1'b0;

        case (q.st)
            SQ_OFF: if (ext_pwr_in || key_rise) begin d.st = SQ_UP1; d.cnt = '0; end
            SQ_UP1: if (pg1_in) begin d.st = SQ_GAP2; d.cnt = '0; end
            SQ_GAP2:
                if (done) begin d.st = SQ_UP2; d.cnt = '0; end
                else d.cnt = q.cnt + 1'b1;
            SQ_UP2: if (pg1_in && pg2_in) begin d.st = SQ_RSTDLY; d.cnt = '0; end
            SQ_RSTDLY:
                if (done) begin d.st = SQ_WIN; d.cnt = '0; end
                else d.cnt = q.cnt + 1'b1;
            SQ_WIN:
                if (hold_in) begin d.st = SQ_ON; d.cnt = '0; end
                else if (done) begin d.st = ext_pwr_in ? SQ_ON : SQ_DROP; d.cnt = '0; end
                else d.cnt = q.cnt + 1'b1;
            SQ_ON:
                if (!hold_in && !ext_pwr_in) begin
                    d.st  = SQ_DROP;
                    d.cnt = '0;
                end else if (key_rise) begin
                    d.irq = 1'b1;
                end else begin
                    d.irq = q.irq && key_held;
                end
            SQ_DROP:
                if (done) begin d.st = SQ_DN2; d.cnt = '0; end
                else d.cnt = q.cnt + 1'b1;
            SQ_DN2:
                if (done) begin d.st = SQ_DN1; d.cnt = '0; end
                else d.cnt = q.cnt + 1'b1;
            SQ_DN1:
                if (done) begin d.st = SQ_OFF; d.cnt = '0; end
                else d.cnt = q.cnt + 1'b1;
            default: begin d.st = SQ_OFF; d.cnt = '0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: SQ_OFF, cnt: '0, key_prev: 1'b0, irq: 1'b0};
        else     q <= d;
    end

    assign reg1_en   = (q.st != SQ_OFF);
    assign reg2_en   = (q.st inside {SQ_UP2, SQ_RSTDLY, SQ_WIN, SQ_ON, SQ_DROP, SQ_DN2});
    assign sys_rst_n = (q.st inside {SQ_WIN, SQ_ON, SQ_DROP});
    assign irq_n     = !q.irq;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
    parameter int unsigned DEB_CYC  = 32000,
    parameter int unsigned EN2_DLY  = 500,
    parameter int unsigned RST_DLY  = 20000,
    parameter int unsigned HOLD_WIN = 500000,
    parameter int unsigned FALL_DLY = 100,
    parameter int unsigned OFF2_DLY = 1000,
    parameter int unsigned OFF1_DLY = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic key_in,
    input  logic ext_pwr_in,
    input  logic hold_in,
    input  logic pg1_in,
    input  logic pg2_in,
    output logic reg1_en,
    output logic reg2_en,
    output logic sys_rst_n,
    output logic irq_n
);
    logic key_held;

    pwr_key_filter #(.DEB_CYC(DEB_CYC)) u_key (
        .clk      (clk),
        .rst      (rst),
        .key_in   (key_in),
        .key_held (key_held)
    );

    pwr_seq_fsm #(
        .EN2_DLY  (EN2_DLY),
        .RST_DLY  (RST_DLY),
        .HOLD_WIN (HOLD_WIN),
        .FALL_DLY (FALL_DLY),
        .OFF2_DLY (OFF2_DLY),
        .OFF1_DLY (OFF1_DLY)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .key_held   (key_held),
        .ext_pwr_in (ext_pwr_in),
        .hold_in    (hold_in),
        .pg1_in     (pg1_in),
        .pg2_in     (pg2_in),
        .reg1_en    (reg1_en),
        .reg2_en    (reg2_en),
        .sys_rst_n  (sys_rst_n),
        .irq_n      (irq_n)
    );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
    input logic clk,
    input logic rst,
    input logic reg1_en,
    input logic reg2_en,
    input logic sys_rst_n,
    input logic irq_n
);
    a_r2_en2_needs_en1: assert property (@(posedge clk) disable iff (rst)
        reg2_en |-> reg1_en);

    a_r2_en2_after_en1: assert property (@(posedge clk) disable iff (rst)
        $rose(reg2_en) |-> $past(reg1_en));

    a_r4_rstn_needs_both: assert property (@(posedge clk) disable iff (rst)
        sys_rst_n |-> (reg1_en && reg2_en));

    a_r7_en2_off_after_rst: assert property (@(posedge clk) disable iff (rst)
        $fell(reg2_en) |-> (!sys_rst_n && $past(!sys_rst_n)));

    a_r7_en1_off_last: assert property (@(posedge clk) disable iff (rst)
        $fell(reg1_en) |-> !reg2_en);

    a_r8_irq_only_on: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (sys_rst_n && reg2_en));

    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!reg1_en && !reg2_en && !sys_rst_n && irq_n));
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg1_en   (reg1_en),
    .reg2_en   (reg2_en),
    .sys_rst_n (sys_rst_n),
    .irq_n     (irq_n)
);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int DEB  = 8;
    localparam int EN2  = 3;
    localparam int RSTD = 5;
    localparam int HOLD = 20;
    localparam int FALL = 2;
    localparam int OFF2 = 3;
    localparam int OFF1 = 4;

    logic clk = 1'b0;
    logic rst, key_in, ext_pwr_in, hold_in, pg1_in, pg2_in;
    logic reg1_en, reg2_en, sys_rst_n, irq_n;

    always #4 clk = ~clk;

    pwr_seq_ctrl #(
        .DEB_CYC(DEB), .EN2_DLY(EN2), .RST_DLY(RSTD), .HOLD_WIN(HOLD),
        .FALL_DLY(FALL), .OFF2_DLY(OFF2), .OFF1_DLY(OFF1)
    ) u0 (
        .clk(clk), .rst(rst), .key_in(key_in), .ext_pwr_in(ext_pwr_in),
        .hold_in(hold_in), .pg1_in(pg1_in), .pg2_in(pg2_in),
        .reg1_en(reg1_en), .reg2_en(reg2_en), .sys_rst_n(sys_rst_n), .irq_n(irq_n)
    );

    typedef struct {
        int         at;
        logic [3:0] v;
        string      tag;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // expected output vector: {reg1_en, reg2_en, sys_rst_n, irq_n}
    task automatic expect_in(int dc, logic [3:0] v, string tag);
        item_t it;
        int i;
        it.at  = cyc + dc;
        it.v   = v;
        it.tag = tag;
        i = sb.size();
        while (i > 0 && sb[i-1].at > it.at) i--;
        sb.insert(i, it);
    endtask

    always @(negedge clk) begin
        item_t it;
        #1;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            it = sb.pop_front();
            checks++;
            if (it.at < cyc) begin
                fails++;
                $display("FAIL %s: check at cycle %0d missed (now %0d)", it.tag, it.at, cyc);
            end else if ({reg1_en, reg2_en, sys_rst_n, irq_n} !== it.v) begin
                fails++;
                $display("FAIL %s: cycle %0d actual=%b expected=%b", it.tag, cyc,
                         {reg1_en, reg2_en, sys_rst_n, irq_n}, it.v);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; key_in = 1'b0; ext_pwr_in = 1'b0; hold_in = 1'b0;
        pg1_in = 1'b0; pg2_in = 1'b0;
        step(3);
        rst = 1'b0;
        expect_in(0, 4'b0001, "R10 reset state");
        step(2);

        // R1: short press ignored
        key_in = 1'b1;
        step(DEB - 1);
        key_in = 1'b0;
        expect_in(0, 4'b0001, "R1 short press");
        expect_in(4, 4'b0001, "R1 short press after release");
        step(6);

        // R1: full press
        key_in = 1'b1;
        expect_in(DEB, 4'b0001, "R1 not before debounce");
        expect_in(DEB + 1, 4'b1001, "R1 reg1 on");
        step(DEB + 1);
        key_in = 1'b0;
        step(2);
        expect_in(0, 4'b1001, "R3 waits for pg1");

        // R3
        pg1_in = 1'b1;
        expect_in(EN2, 4'b1001, "R3 gap");
        expect_in(EN2 + 1, 4'b1101, "R3 reg2 on");
        step(EN2 + 3);
        expect_in(0, 4'b1101, "R4 waits for pg2");

        // R4
        pg2_in = 1'b1;
        expect_in(RSTD, 4'b1101, "R4 reset held");
        expect_in(RSTD + 1, 4'b1111, "R4 reset released");
        step(RSTD + 1);
        step(3);
        hold_in = 1'b1;
        step(HOLD + 2);
        expect_in(0, 4'b1111, "R5 hold in window keeps on");

        // R8: interrupt on a new press
        key_in = 1'b1;
        expect_in(DEB, 4'b1111, "R8 irq not yet");
        expect_in(DEB + 1, 4'b1110, "R8 irq low");
        step(DEB + 3);
        expect_in(0, 4'b1110, "R8 irq held, no power change");
        key_in = 1'b0;
        expect_in(1, 4'b1110, "R8 irq until filter clears");
        expect_in(2, 4'b1111, "R8 irq released");
        step(4);

        // R6, R7: hold drop shutdown
        hold_in = 1'b0;
        expect_in(FALL, 4'b1111, "R6 reset still high");
        expect_in(FALL + 1, 4'b1101, "R6 reset low");
        expect_in(FALL + OFF2, 4'b1101, "R7 reg2 still on");
        expect_in(FALL + 1 + OFF2, 4'b1001, "R7 reg2 off");
        expect_in(FALL + OFF2 + OFF1, 4'b1001, "R7 reg1 still on");
        expect_in(FALL + 1 + OFF2 + OFF1, 4'b0001, "R7 reg1 off");
        step(FALL + OFF2 + OFF1 + 4);

        // R5: window timeout (pg flags stay high)
        key_in = 1'b1;
        expect_in(DEB + 1, 4'b1001, "R1 second power-up");
        step(DEB + 1);
        key_in = 1'b0;
        expect_in(1 + EN2, 4'b1101, "R3 reg2 on with pg1 already high");
        expect_in(1 + EN2 + RSTD, 4'b1101, "R4 reset held");
        expect_in(2 + EN2 + RSTD, 4'b1111, "R4 reset released");
        expect_in(2 + EN2 + RSTD + HOLD + FALL - 1, 4'b1111, "R5 window still open");
        expect_in(2 + EN2 + RSTD + HOLD + FALL, 4'b1101, "R5 timeout reset low");
        expect_in(2 + EN2 + RSTD + HOLD + FALL + OFF2, 4'b1001, "R7 reg2 off after timeout");
        expect_in(2 + EN2 + RSTD + HOLD + FALL + OFF2 + OFF1, 4'b0001, "R7 reg1 off after timeout");
        step(2 + EN2 + RSTD + HOLD + FALL + OFF2 + OFF1 + 4);

        // R2, R9: external supply
        ext_pwr_in = 1'b1;
        expect_in(0, 4'b0001, "R2 before ext edge");
        expect_in(1, 4'b1001, "R2 reg1 on from ext");
        expect_in(3 + EN2 + RSTD + HOLD + 3, 4'b1111, "R9 window expiry ignored");
        step(3 + EN2 + RSTD + HOLD + 4);
        hold_in = 1'b1;
        step(3);
        hold_in = 1'b0;
        expect_in(FALL + OFF2 + 3, 4'b1111, "R9 hold drop ignored");
        step(FALL + OFF2 + 4);
        ext_pwr_in = 1'b0;
        expect_in(FALL, 4'b1111, "R9 reset high until delay");
        expect_in(FALL + 1, 4'b1101, "R9 shutdown after ext drop");
        expect_in(FALL + 1 + OFF2 + OFF1, 4'b0001, "R9 off after ext drop");
        step(FALL + OFF2 + OFF1 + 4);

        // R10: reset mid-sequence
        ext_pwr_in = 1'b1;
        step(3 + EN2 + RSTD + 2);
        expect_in(0, 4'b1111, "R10 on before reset");
        rst = 1'b1;
        ext_pwr_in = 1'b0;
        expect_in(1, 4'b0001, "R10 reset forces off");
        step(2);
        rst = 1'b0;
        expect_in(2, 4'b0001, "R10 stays off");
        step(4);

        while (sb.size() > 0) step(1);
        step(2);
        finish_run();
    end
endmodule